// File: doc/BRIEF.md
# I2C Single-Controller Byte Engine

This block is the bus-controller side of an I2C link, reached through a small register window: one 32-bit control/status word and one data word. Software sets it up, asks for a START, writes a byte to send, and asks for a STOP. Each byte moves in both directions at once. Bits leave on SDA, most significant first, and the levels seen on SDA at each rising clock are shifted in. When the byte is done the data word holds the captured byte. To read from a peripheral, software sends 0xFF so that the peripheral alone decides each bit.

In the ninth (acknowledge) slot the engine does one of two things. It can release SDA and record whether the peripheral pulled it low, or it can pull SDA low itself as the controller's own acknowledge. Both lines are open-drain: the block only pulls them low or lets go, and it watches each line through its own sense input. The sense inputs pass through a synchronizer. Quarter-period timing comes from an external tick. The rate fields stored in the control word are handed out on a port for that external timebase. When clock stretching is allowed, the engine waits while a peripheral holds SCL low. A bus-claimed status bit and a one-cycle done pulse per byte complete the block.

Top module: `i2cb_ctrl`

## Requirements
- R1: After reset both line outputs are released (1), the control word reads 0, the data word reads 0 and the done pulse is low.
- R2: Control word layout: bit 0 enable, bit 1 START request, bit 2 STOP request, bit 3 controller-acknowledge, bit 4 stretch allow, bits 7:5 rate select, bits 11:8 fine divider. Bits 1 and 2 always read 0. Bits 28:12 read 0. Bits 31:29 ignore writes. The rate fields appear on `rate_sel` as {bits 11:8, bits 7:5}.
- R3: A START request, accepted only while enable was already 1 and the engine idle, makes SDA fall while SCL is high. It leaves both lines pulled low. Busy (bit 31) is 1 until it completes.
- R4: A STOP request makes SDA rise while SCL is high and leaves both lines released.
- R5: Writing the data word (offset 4, bits 7:0) sends the byte most significant bit first. SDA changes only while SCL is low.
- R6: After a transfer the data word reads the byte sampled on SDA at the eight rising SCL edges. This byte is the wired-AND of the sent byte and the peripheral's bits.
- R7: With controller-acknowledge off, SDA is released in the ninth slot. Bit 30 reads 1 if SDA was sampled low there (ACK) and 0 if high (NACK).
- R8: With controller-acknowledge on, the block pulls SDA low in the ninth slot.
- R9: With stretch allow on, the sequence waits while SCL stays low after the block released it. With it off, the sequence runs on regardless.
- R10: Bit 29 reads 1 exactly when both sensed lines are low, whoever drives them (after the synchronizer delay).
- R11: `done_irq` pulses for one cycle at the end of each byte transfer and never for a START or STOP.
- R12: While busy, writes to the data word and START/STOP requests have no effect.
- R13: Clearing enable aborts any operation, clears internal state (data word reads 0) and releases both lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Quarter-SCL-period step strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Byte offset: 0 control, 4 data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| rate_sel | output | 7 | Stored divider and rate fields for the timebase |
| done_irq | output | 1 | One-cycle pulse per finished byte |
| scl_i | input | 1 | SCL line sense |
| sda_i | input | 1 | SDA line sense |
| scl_o | output | 1 | SCL pull-low (0) or release (1) |
| sda_o | output | 1 | SDA pull-low (0) or release (1) |

## Verification
The byte engine is driven by a table of six cases that combine sent bytes, peripheral bit patterns, peripheral ACK or NACK, and acknowledge mode on or off. These cases separate a plain write (peripheral all ones), a read (0xFF sent), a mixed wired-AND, and a controller acknowledge that masks a peripheral NACK. The bits captured on SDA at each SCL rise show MSB-first order and the ninth-slot drive. Directed runs hold SCL low with stretching on and then off to show that the engine waits or does not. They also pull both lines externally to exercise the claimed flag, write while busy, and drop enable mid-byte.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

    localparam int REG_W     = 32;
    localparam int ADDR_W    = 3;
    localparam int PRSC_W    = 3;
    localparam int CDIV_W    = 4;
    localparam int RATE_W    = PRSC_W + CDIV_W;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_DATA = 3'd4;

    // bit positions of the control/status word
    localparam int B_EN      = 0;
    localparam int B_START   = 1;
    localparam int B_STOP    = 2;
    localparam int B_MACK    = 3;
    localparam int B_CSEN    = 4;
    localparam int B_PRSC_LO = 5;
    localparam int B_CDIV_LO = 8;
    localparam int B_CLAIM   = 29;
    localparam int B_ACK     = 30;
    localparam int B_BUSY    = 31;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_START = 2'd1,
        OP_STOP  = 2'd2,
        OP_XFER  = 2'd3
    } op_e;

    typedef struct packed {
        logic              en;
        logic              mack;
        logic              csen;
        logic [PRSC_W-1:0] prsc;
        logic [CDIV_W-1:0] cdiv;
    } cfg_t;

    typedef struct packed {
        logic busy;
        logic ack;
        logic claimed;
    } stat_t;

    function automatic cfg_t decode_cfg(input logic [REG_W-1:0] w);
        cfg_t c;
        c.en   = w[B_EN];
        c.mack = w[B_MACK];
        c.csen = w[B_CSEN];
        c.prsc = w[B_PRSC_LO +: PRSC_W];
        c.cdiv = w[B_CDIV_LO +: CDIV_W];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(input cfg_t c, input stat_t s);
        logic [REG_W-1:0] r;
        r = '0;
        r[B_EN]                 = c.en;
        r[B_MACK]               = c.mack;
        r[B_CSEN]               = c.csen;
        r[B_PRSC_LO +: PRSC_W]  = c.prsc;
        r[B_CDIV_LO +: CDIV_W]  = c.cdiv;
        r[B_CLAIM]              = s.claimed;
        r[B_ACK]                = s.ack;
        r[B_BUSY]               = s.busy;
        return r;
    endfunction

    // line levels {scl, sda} for each quarter of a START or STOP condition
    function automatic logic [1:0] cond_drive(input op_e op, input logic [1:0] q,
                                              input logic idle_scl, input logic idle_sda);
        logic [1:0] d;
        d = {idle_scl, idle_sda};
        if (op == OP_START) begin
            case (q)
                2'd0:    d = {idle_scl, 1'b1};
                2'd1:    d = 2'b11;
                2'd2:    d = 2'b10;
                default: d = 2'b00;
            endcase
        end else if (op == OP_STOP) begin
            case (q)
                2'd0:    d = {1'b0, idle_sda};
                2'd1:    d = 2'b00;
                2'd2:    d = 2'b10;
                default: d = 2'b11;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/i2cb_line_sync.sv
module i2cb_line_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] synced,
    output logic             claimed
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], raw[i]};
        end
        assign synced[i] = chain[STAGES-1];
    end

    assign claimed = ~|synced;

endmodule

// File: rtl/i2cb_regs.sv
module i2cb_regs
    import i2cb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  stat_t             stat,
    input  logic [DATA_W-1:0] rx_byte,
    output cfg_t              cfg,
    output logic              cmd_start,
    output logic              cmd_stop,
    output logic              cmd_byte,
    output logic [DATA_W-1:0] tx_byte
);

    logic wr_ctrl, wr_data, may_cmd;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_data = bus_wr && (bus_addr == ADDR_DATA);
    assign may_cmd = cfg.en && !stat.busy;

    always_ff @(posedge clk) begin
        if (rst)          cfg <= '0;
        else if (wr_ctrl) cfg <= decode_cfg(bus_wdata);
    end

    assign cmd_start = wr_ctrl && may_cmd && bus_wdata[B_EN] && bus_wdata[B_START];
    assign cmd_stop  = wr_ctrl && may_cmd && bus_wdata[B_EN] && bus_wdata[B_STOP]
                       && !bus_wdata[B_START];
    assign cmd_byte  = wr_data && may_cmd;
    assign tx_byte   = bus_wdata[DATA_W-1:0];

    always_comb begin
        case (bus_addr)
            ADDR_CTRL: bus_rdata = pack_ctrl(cfg, stat);
            ADDR_DATA: bus_rdata = {{(REG_W-DATA_W){1'b0}}, rx_byte};
            default:   bus_rdata = '0;
        endcase
    end

    // R12
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        stat.busy |-> !(cmd_start || cmd_stop || cmd_byte));

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_CTRL) |-> (bus_rdata[28:12] == '0 && bus_rdata[2:1] == 2'b00));

endmodule

// File: rtl/i2cb_engine.sv
module i2cb_engine
    import i2cb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              mack,
    input  logic              csen,
    input  logic              tick,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              cmd_byte,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              scl_s,
    input  logic              sda_s,
    output logic              scl_o,
    output logic              sda_o,
    output logic              busy,
    output logic              ack,
    output logic [DATA_W-1:0] rx_byte,
    output logic              done_irq
);

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

    op_e               op;
    logic [1:0]        q;
    logic [CNT_W-1:0]  bitn;
    logic [DATA_W-1:0] shift;
    logic              samp;
    logic              ack_r;
    logic              idle_scl, idle_sda;
    logic              irq_r;
    logic              stretch_wait;
    logic [1:0]        cond_lv;

    assign stretch_wait = csen && !scl_s;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            op       <= OP_IDLE;
            q        <= '0;
            bitn     <= '0;
            shift    <= '0;
            samp     <= 1'b1;
            ack_r    <= 1'b0;
            idle_scl <= 1'b1;
            idle_sda <= 1'b1;
            irq_r    <= 1'b0;
        end else begin
            irq_r <= 1'b0;
            case (op)
                OP_IDLE: begin
                    q <= '0;
                    if (cmd_start) begin
                        op <= OP_START;
                    end else if (cmd_stop) begin
                        op <= OP_STOP;
                    end else if (cmd_byte) begin
                        op    <= OP_XFER;
                        bitn  <= '0;
                        shift <= tx_byte;
                    end
                end
                OP_START, OP_STOP: begin
                    if (tick) begin
                        if (q == 2'd3) begin
                            op       <= OP_IDLE;
                            idle_scl <= (op == OP_STOP);
                            idle_sda <= (op == OP_STOP);
                        end else begin
                            q <= q + 2'd1;
                        end
                    end
                end
                OP_XFER: begin
                    if (tick) begin
                        if (q == 2'd2) begin
                            if (!stretch_wait) begin
                                q <= 2'd3;
                                if (bitn == LAST) ack_r <= !sda_s;
                                else              samp  <= sda_s;
                            end
                        end else if (q == 2'd3) begin
                            q <= 2'd0;
                            if (bitn == LAST) begin
                                op       <= OP_IDLE;
                                idle_scl <= 1'b0;
                                idle_sda <= 1'b1;
                                irq_r    <= 1'b1;
                            end else begin
                                shift <= {shift[DATA_W-2:0], samp};
                                bitn  <= bitn + 1'b1;
                            end
                        end else begin
                            q <= q + 2'd1;
                        end
                    end
                end
                default: op <= OP_IDLE;
            endcase
        end
    end

    assign cond_lv = cond_drive(op, q, idle_scl, idle_sda);

    always_comb begin
        case (op)
            OP_XFER: begin
                scl_o = q[1];
                sda_o = (bitn == LAST) ? !mack : shift[DATA_W-1];
            end
            OP_START, OP_STOP: begin
                scl_o = cond_lv[1];
                sda_o = cond_lv[0];
            end
            default: begin
                scl_o = idle_scl;
                sda_o = idle_sda;
            end
        endcase
    end

    assign busy     = (op != OP_IDLE);
    assign ack      = ack_r;
    assign rx_byte  = shift;
    assign done_irq = irq_r;

    // R5
    sda_steady_high_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_XFER && $past(op) == OP_XFER && scl_o && $past(scl_o))
        |-> (sda_o == $past(sda_o)));

    // R11
    irq_byte_only_chk: assert property (@(posedge clk) disable iff (rst)
        done_irq |-> ($past(op) == OP_XFER && op == OP_IDLE));

    // R13
    abort_release_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!busy && scl_o && sda_o));

    // R9
    stretch_pause_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_XFER && q == 2'd2 && tick && csen && !scl_s && en)
        |=> (scl_o && $stable(bitn) && busy));

endmodule

// File: rtl/i2cb_ctrl.sv
module i2cb_ctrl
    import i2cb_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [RATE_W-1:0] rate_sel,
    output logic              done_irq,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_o,
    output logic              sda_o
);

    cfg_t              cfg;
    stat_t             stat;
    logic              cmd_start, cmd_stop, cmd_byte;
    logic [DATA_W-1:0] tx_byte, rx_byte;
    logic [1:0]        sense;
    logic              claimed, busy, ack;

    i2cb_line_sync #(
        .STAGES (SYNC_STAGES),
        .LINES  (2)
    ) i_sync (
        .clk     (clk),
        .rst     (rst),
        .raw     ({scl_i, sda_i}),
        .synced  (sense),
        .claimed (claimed)
    );

    i2cb_regs #(
        .DATA_W (DATA_W)
    ) i_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .stat      (stat),
        .rx_byte   (rx_byte),
        .cfg       (cfg),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .cmd_byte  (cmd_byte),
        .tx_byte   (tx_byte)
    );

    i2cb_engine #(
        .DATA_W (DATA_W)
    ) i_engine (
        .clk       (clk),
        .rst       (rst),
        .en        (cfg.en),
        .mack      (cfg.mack),
        .csen      (cfg.csen),
        .tick      (tick),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .cmd_byte  (cmd_byte),
        .tx_byte   (tx_byte),
        .scl_s     (sense[1]),
        .sda_s     (sense[0]),
        .scl_o     (scl_o),
        .sda_o     (sda_o),
        .busy      (busy),
        .ack       (ack),
        .rx_byte   (rx_byte),
        .done_irq  (done_irq)
    );

    assign stat.busy    = busy;
    assign stat.ack     = ack;
    assign stat.claimed = claimed;
    assign rate_sel     = {cfg.cdiv, cfg.prsc};

endmodule

// File: tb/test_i2cb_ctrl.sv
module test_i2cb_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [6:0]  rate_sel;
    logic        done_irq;
    logic        scl_o, sda_o, scl_line, sda_line;
    logic        ext_scl_low = 1'b0, ext_sda_low = 1'b0;

    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    // quarter-period timebase: one tick every 4 clocks
    logic [1:0] tcnt = '0;
    always @(posedge clk) tcnt <= tcnt + 2'd1;
    assign tick = (tcnt == 2'd3);

    // peripheral model: 8 data bits then ack level (0 = ACK), advanced on SCL falls
    logic [8:0] pbits = 9'h1FF;
    int         xfer_id = 0, seen_id = 0, pidx = 0;
    logic       prev_scl = 1'b1, prev_sda = 1'b1;
    logic       periph_sda;
    assign periph_sda = (pidx <= 8) ? pbits[8 - pidx] : 1'b1;
    assign scl_line   = scl_o & ~ext_scl_low;
    assign sda_line   = sda_o & periph_sda & ~ext_sda_low;

    int         irq_cnt = 0, start_cnt = 0, stop_cnt = 0;
    logic [15:0] cap = '0;

    always @(posedge clk) begin
        if (seen_id != xfer_id) begin
            seen_id <= xfer_id;
            pidx    <= 0;
        end else if (prev_scl && !scl_line) begin
            pidx <= pidx + 1;
        end
        prev_scl <= scl_line;
        prev_sda <= sda_line;
        if (prev_scl && scl_line && prev_sda && !sda_line) start_cnt <= start_cnt + 1;
        if (prev_scl && scl_line && !prev_sda && sda_line) stop_cnt <= stop_cnt + 1;
        if (!prev_scl && scl_line) cap <= {cap[14:0], sda_o};
        if (done_irq) irq_cnt <= irq_cnt + 1;
    end

    i2cb_ctrl i_i2cb_ctrl (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rate_sel  (rate_sel),
        .done_irq  (done_irq),
        .scl_i     (scl_line),
        .sda_i     (sda_line),
        .scl_o     (scl_o),
        .sda_o     (sda_o)
    );

    typedef struct packed {
        logic       mack;
        logic       pack;
        logic [7:0] tx;
        logic [7:0] pd;
        logic [7:0] exp_rx;
        logic       exp_ack;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{1'b0, 1'b0, 8'hA5, 8'hFF, 8'hA5, 1'b1},
        '{1'b0, 1'b1, 8'h3C, 8'hFF, 8'h3C, 1'b0},
        '{1'b0, 1'b0, 8'hFF, 8'h5A, 8'h5A, 1'b1},
        '{1'b1, 1'b1, 8'hFF, 8'hC3, 8'hC3, 1'b1},
        '{1'b0, 1'b0, 8'h81, 8'h0F, 8'h01, 1'b1},
        '{1'b1, 1'b0, 8'h00, 8'hFF, 8'h00, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 5000; i++) begin
            rd(3'd0, v);
            if (!v[31]) break;
        end
    endtask

    task automatic send(input logic [7:0] b, input logic [8:0] periph);
        pbits = periph;
        xfer_id++;
        wr(3'd4, {24'h0, b});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int s0, p0, i0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 reset state
        rd(3'd0, v); chk("R1 ctrl", v, 32'h0);
        rd(3'd4, v); chk("R1 data", v, 32'h0);
        chk("R1 lines", {30'h0, scl_o, sda_o}, 32'h3);
        chk("R1 irq", {31'h0, done_irq}, 32'h0);

        // R2 layout, reserved and write-only bits
        wr(3'd0, 32'h0000_0FF9);
        rd(3'd0, v); chk("R2 fields", v, 32'h0000_0FF9);
        chk("R2 rate_sel", {25'h0, rate_sel}, 32'h7F);
        wr(3'd0, 32'hFFFF_FFF8);
        rd(3'd0, v); chk("R2 reserved", v, 32'h0000_0FF8);
        wr(3'd0, 32'h0);

        // table of byte transfers: R3 R5 R6 R7 R8 R11
        for (int k = 0; k < 6; k++) begin
            logic [31:0] base;
            base = {28'h0, VECS[k].mack, 3'b001};
            wr(3'd0, base);
            s0 = start_cnt; i0 = irq_cnt;
            wr(3'd0, base | 32'h2);
            wait_idle();
            repeat (2) @(negedge clk);
            chk("R3 start seen", start_cnt - s0, 1);
            chk("R3 lines low", {30'h0, scl_o, sda_o}, 32'h0);
            chk("R11 no irq on start", irq_cnt - i0, 0);
            send(VECS[k].tx, {VECS[k].pd, VECS[k].pack});
            wait_idle();
            repeat (2) @(negedge clk);
            rd(3'd4, v); chk("R6 rx byte", v, {24'h0, VECS[k].exp_rx});
            rd(3'd0, v); chk("R7 ack bit", {31'h0, v[30]}, {31'h0, VECS[k].exp_ack});
            chk("R5 msb first", {24'h0, cap[8:1]}, {24'h0, VECS[k].tx});
            chk("R8 ninth slot drive", {31'h0, cap[0]}, {31'h0, ~VECS[k].mack});
            chk("R11 one irq per byte", irq_cnt - i0, 1);
        end

        // R4 stop
        p0 = stop_cnt; i0 = irq_cnt;
        wr(3'd0, 32'h5);
        wait_idle();
        repeat (2) @(negedge clk);
        chk("R4 stop seen", stop_cnt - p0, 1);
        chk("R4 lines released", {30'h0, scl_o, sda_o}, 32'h3);
        chk("R11 no irq on stop", irq_cnt - i0, 0);

        // R12 writes while busy are ignored
        wr(3'd0, 32'h3); wait_idle();
        s0 = start_cnt;
        send(8'hA5, 9'h1FF);
        repeat (10) @(negedge clk);
        wr(3'd4, 32'h00);
        wr(3'd0, 32'h3);
        wait_idle();
        repeat (2) @(negedge clk);
        rd(3'd4, v); chk("R12 data write ignored", v, 32'hA5);
        chk("R12 start ignored", start_cnt - s0, 0);
        repeat (20) @(negedge clk);
        rd(3'd0, v); chk("R12 no late op", {31'h0, v[31]}, 32'h0);

        // R9 stretching honoured
        wr(3'd0, 32'h11); wr(3'd0, 32'h13); wait_idle();
        ext_scl_low = 1'b1;
        send(8'hFF, {8'h96, 1'b0});
        repeat (300) @(negedge clk);
        rd(3'd0, v); chk("R9 paused while held", {31'h0, v[31]}, 32'h1);
        ext_scl_low = 1'b0;
        wait_idle();
        rd(3'd4, v); chk("R9 byte after release", v, 32'h96);
        // R9 stretching off: runs on
        wr(3'd0, 32'h01); wr(3'd0, 32'h03); wait_idle();
        ext_scl_low = 1'b1;
        send(8'hFF, 9'h1FF);
        repeat (300) @(negedge clk);
        rd(3'd0, v); chk("R9 no pause when off", {31'h0, v[31]}, 32'h0);
        ext_scl_low = 1'b0;

        // R13 abort mid-byte
        wr(3'd0, 32'h03); wait_idle();
        i0 = irq_cnt;
        send(8'h55, 9'h1FF);
        repeat (40) @(negedge clk);
        wr(3'd0, 32'h0);
        repeat (3) @(negedge clk);
        chk("R13 lines released", {30'h0, scl_o, sda_o}, 32'h3);
        rd(3'd0, v); chk("R13 idle", v, 32'h0);
        rd(3'd4, v); chk("R13 data cleared", v, 32'h0);
        repeat (200) @(negedge clk);
        chk("R13 no irq", irq_cnt - i0, 0);

        // R10 bus claimed by another controller
        ext_scl_low = 1'b1; ext_sda_low = 1'b1;
        repeat (4) @(negedge clk);
        rd(3'd0, v); chk("R10 claimed both low", {31'h0, v[29]}, 32'h1);
        ext_sda_low = 1'b0;
        repeat (4) @(negedge clk);
        rd(3'd0, v); chk("R10 scl only low", {31'h0, v[29]}, 32'h0);
        ext_scl_low = 1'b0;
        repeat (4) @(negedge clk);
        rd(3'd0, v); chk("R10 released", {31'h0, v[29]}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule